// File: doc/BRIEF.md
# Rotating Byte/Halfword Extend Execute Unit

This unit executes the byte and halfword extension group of a 32-bit load/store-architecture instruction set. Each cycle it can accept one instruction word, the values of its two source registers and the current N, Z, C and V flags. One cycle later it returns the destination register index, the computed value and a write strobe. It also returns two side flags: one for an unpredictable register choice and one for a word that is not part of this group.

The source operand is first rotated right by a whole number of bytes. The low byte or halfword of the rotated value is then sign- or zero-extended to the full width. A base register value may optionally be added to the result. The register file and the fetch path belong to the caller. Words from the dual-lane (two 16-bit halves) form of the group are reported as not matching.

Top module: `xtnd_exec_unit`

## Requirements
- R1: A word matches only when bits[27:23] = 01101, bits[9:4] = 000111, bits[21:20] is 10 or 11, and bits[31:28] is not 1111. Any other word raises `no_match` with `wr_en` low.
- R2: The source index Rm sits in bits[3:0], the destination Rd in bits[15:12], the base Rn in bits[19:16] and the rotate code in bits[11:10]. On a write, `rd_idx` returns Rd.
- R3: Rotate code k rotates the `rm_val` operand right by 8*k bits before any extraction.
- R4: When bits[21:20] = 10 the low byte is taken; when it is 11 the low halfword is taken. Bit 22 = 1 zero-extends the taken field and bit 22 = 0 sign-extends it to 32 bits.
- R5: When Rn = 1111, the result is the extended value alone and `rn_val` is ignored.
- R6: For any other Rn, the result is `rn_val` plus the extended value, wrapping modulo 2^32.
- R7: When a matching word has Rd = 15 or Rm = 15, `unpred` rises and `wr_en` stays low, whatever the condition.
- R8: Condition codes 0000 to 1110 are evaluated against `flags_nzcv` = {N,Z,C,V}, in the order EQ, NE, CS, CC, MI, PL, VS, VC, HI, LS, GE, LT, GT, LE, AL. When the condition fails, `wr_en` stays low and neither `unpred` nor `no_match` is raised by the condition itself.
- R9: All outputs are registered. `out_valid` and the strobes reflect the `in_valid` of the previous cycle, so a cycle with no input gives low strobes on the next cycle.
- R10: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction word is presented this cycle |
| insn | input | 32 | Instruction word |
| rn_val | input | 32 | Value of the base register |
| rm_val | input | 32 | Value of the source register |
| flags_nzcv | input | 4 | Condition flags {N,Z,C,V} |
| out_valid | output | 1 | The outputs belong to the word presented one cycle earlier |
| wr_en | output | 1 | Write `result` to register `rd_idx` |
| rd_idx | output | 4 | Destination register index |
| result | output | 32 | Computed value |
| unpred | output | 1 | Matching word names register 15 as Rd or Rm |
| no_match | output | 1 | Word is outside this group |

## Verification
The main function is exercised with every rotate code crossed with both sizes, both signedness settings, and both the plain and the accumulate form. Operand bytes are chosen with the top bit set and also clear, so a missing or wrong sign extension shows up, and a wrong rotation picks a byte that differs from the correct one. Every condition code is swept over all sixteen flag combinations, which separates each code from its inverse and from its neighbours. Edge words cover the dual-lane size, condition 1111, corrupted fixed bits, register 15 in each role, and a base value that wraps on the add.

// File: rtl/xtnd_pkg.sv
package xtnd_pkg;
    localparam int XW     = 32;
    localparam int IDX_W  = 4;
    localparam int LANE_W = 8;
    localparam int ROT_N  = 4;
    localparam int ROT_W  = $clog2(ROT_N);

    typedef struct packed {
        logic             match;
        logic             zext;
        logic             half;
        logic             plain;
        logic             unpred;
        logic [3:0]       cond;
        logic [IDX_W-1:0] rd;
        logic [ROT_W-1:0] rot;
    } dec_t;

    typedef struct packed {
        logic             vld;
        logic             wr;
        logic             unp;
        logic             nm;
        logic [IDX_W-1:0] rd;
        logic [XW-1:0]    res;
    } stage_t;
endpackage

// File: rtl/xtnd_decode.sv
module xtnd_decode
    import xtnd_pkg::*;
(
    input  logic [XW-1:0] insn,
    output dec_t          dec
);
    localparam logic [4:0] MAJOR = 5'b01101;
    localparam logic [5:0] MINOR = 6'b000111;
    localparam logic [IDX_W-1:0] PC_IDX = '1;

    logic [1:0] size_f;
    logic [IDX_W-1:0] rn_f, rm_f;

    always_comb begin
        size_f     = insn[21:20];
        rn_f       = insn[19:16];
        rm_f       = insn[3:0];
        dec.cond   = insn[31:28];
        dec.rd     = insn[15:12];
        dec.rot    = insn[11:10];
        dec.zext   = insn[22];
        dec.half   = size_f[0];
        dec.plain  = (rn_f == PC_IDX);
        dec.match  = (insn[27:23] == MAJOR) && (insn[9:4] == MINOR) &&
                     size_f[1] && (dec.cond != 4'hF);
        dec.unpred = (dec.rd == PC_IDX) || (rm_f == PC_IDX);
    end
endmodule

// File: rtl/xtnd_cond.sv
module xtnd_cond (
    input  logic [3:0] cond,
    input  logic [3:0] nzcv,
    output logic       pass
);
    logic n, z, c, v, base;

    always_comb begin
        {n, z, c, v} = nzcv;
        unique case (cond[3:1])
            3'd0: base = z;
            3'd1: base = c;
            3'd2: base = n;
            3'd3: base = v;
            3'd4: base = c & ~z;
            3'd5: base = (n == v);
            3'd6: base = ~z & (n == v);
            default: base = 1'b1;
        endcase
        pass = (cond[3:1] == 3'd7) ? 1'b1 : (base ^ cond[0]);
    end
endmodule

// File: rtl/xtnd_datapath.sv
module xtnd_datapath
    import xtnd_pkg::*;
(
    input  logic [XW-1:0]    rm_val,
    input  logic [XW-1:0]    rn_val,
    input  logic [ROT_W-1:0] rot,
    input  logic             half,
    input  logic             zext,
    input  logic             plain,
    output logic [XW-1:0]    res
);
    localparam int HALF_W = 2 * LANE_W;

    logic [XW-1:0] taps [ROT_N];
    logic [XW-1:0] rotated, ext, addend;

    for (genvar k = 0; k < ROT_N; k++) begin : g_tap
        if (k == 0) begin : g_id
            assign taps[k] = rm_val;
        end else begin : g_rr
            assign taps[k] = {rm_val[k*LANE_W-1:0], rm_val[XW-1:k*LANE_W]};
        end
    end

    always_comb begin
        rotated = taps[rot];
        if (half)
            ext = {{(XW-HALF_W){~zext & rotated[HALF_W-1]}}, rotated[HALF_W-1:0]};
        else
            ext = {{(XW-LANE_W){~zext & rotated[LANE_W-1]}}, rotated[LANE_W-1:0]};
        addend = plain ? '0 : rn_val;
        res    = addend + ext;
    end
endmodule

// File: rtl/xtnd_exec_unit.sv
module xtnd_exec_unit
    import xtnd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] insn,
    input  logic [31:0] rn_val,
    input  logic [31:0] rm_val,
    input  logic [3:0]  flags_nzcv,
    output logic        out_valid,
    output logic        wr_en,
    output logic [3:0]  rd_idx,
    output logic [31:0] result,
    output logic        unpred,
    output logic        no_match
);
    dec_t          dec;
    logic          cpass;
    logic [XW-1:0] dp_res;
    stage_t        st_d, st_q;

    xtnd_decode u_dec (.insn(insn), .dec(dec));

    xtnd_cond u_cond (.cond(dec.cond), .nzcv(flags_nzcv), .pass(cpass));

    xtnd_datapath u_dp (
        .rm_val(rm_val), .rn_val(rn_val), .rot(dec.rot), .half(dec.half),
        .zext(dec.zext), .plain(dec.plain), .res(dp_res)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.wr  = in_valid & dec.match & cpass & ~dec.unpred;
        st_d.unp = in_valid & dec.match & dec.unpred;
        st_d.nm  = in_valid & ~dec.match;
        if (in_valid) begin
            st_d.rd  = dec.rd;
            st_d.res = dp_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign wr_en     = st_q.wr;
    assign rd_idx    = st_q.rd;
    assign result    = st_q.res;
    assign unpred    = st_q.unp;
    assign no_match  = st_q.nm;

    a_r9_strobe_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || unpred || no_match) |-> out_valid);
    a_r9_valid_from_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    a_r7_unpred_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        unpred |-> !wr_en);
    a_r1_nomatch_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        no_match |-> (!wr_en && !unpred));
    a_r8_always_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && insn[31:28] == 4'hE && insn[27:23] == 5'b01101 &&
         insn[9:4] == 6'b000111 && insn[21] && insn[15:12] != 4'hF && insn[3:0] != 4'hF)
        |=> wr_en);
endmodule

// File: tb/sim_xtnd_exec_unit.sv
module sim_xtnd_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0, rn_val = '0, rm_val = '0;
    logic [3:0]  flags_nzcv = '0;
    logic        out_valid, wr_en, unpred, no_match;
    logic [3:0]  rd_idx;
    logic [31:0] result;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    xtnd_exec_unit u0 (.*);

    function automatic logic [31:0] mk(input logic [3:0] c, input bit u, input logic [1:0] sz,
                                       input logic [3:0] n, input logic [3:0] d,
                                       input logic [1:0] r, input logic [3:0] m);
        return {c, 5'b01101, u, sz, n, d, r, 6'b000111, m};
    endfunction

    function automatic bit cond_ok(input logic [3:0] c, input logic [3:0] f);
        bit n = f[3], z = f[2], cf = f[1], v = f[0];
        case (c)
            0: return z;          1: return !z;
            2: return cf;         3: return !cf;
            4: return n;          5: return !n;
            6: return v;          7: return !v;
            8: return cf && !z;   9: return !cf || z;
            10: return n == v;    11: return n != v;
            12: return !z && (n == v);
            13: return z || (n != v);
            default: return 1;
        endcase
    endfunction

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply one word, then compare every output one cycle later.
    task automatic apply(input string tag, input logic [31:0] w, input logic [31:0] a,
                         input logic [31:0] b, input logic [3:0] f);
        bit good, unp, wr;
        longint unsigned ext, rot2;
        int sh;
        logic [63:0] dbl;
        logic [31:0] rr, e_res;
        insn = w; rn_val = a; rm_val = b; flags_nzcv = f; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        good = (w[27:23] == 5'b01101) && (w[9:4] == 6'b000111) && (w[21:20] >= 2'b10)
               && (w[31:28] != 4'hF);
        unp  = good && (w[15:12] == 15 || w[3:0] == 15);
        wr   = good && !unp && cond_ok(w[31:28], f);
        sh   = 8 * int'(w[11:10]);
        dbl  = {b, b} >> sh;
        rr   = dbl[31:0];
        if (w[20]) ext = w[22] ? {48'd0, rr[15:0]} : longint'(signed'(rr[15:0]));
        else       ext = w[22] ? {56'd0, rr[7:0]}  : longint'(signed'(rr[7:0]));
        rot2  = (w[19:16] == 4'hF) ? ext : ext + {32'd0, a};
        e_res = rot2[31:0];
        chk({tag, " R9 out_valid"}, {31'd0, out_valid}, 32'd1);
        chk({tag, " R1 no_match"}, {31'd0, no_match}, {31'd0, !good});
        chk({tag, " R7 unpred"}, {31'd0, unpred}, {31'd0, unp});
        chk({tag, " R8 wr_en"}, {31'd0, wr_en}, {31'd0, wr});
        if (wr) begin
            chk({tag, " R2 rd_idx"}, {28'd0, rd_idx}, {28'd0, w[15:12]});
            chk({tag, " R3 R4 R5 R6 result"}, result, e_res);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            misses++;
            vectors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        chk("R10 reset out_valid", {31'd0, out_valid}, 0);
        chk("R10 reset wr_en", {31'd0, wr_en}, 0);
        chk("R10 reset result", result, 0);
        chk("R10 reset flags", {29'd0, unpred, no_match, |rd_idx}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R5 R6: every rotation, size, signedness and form
        for (int u = 0; u < 2; u++)
            for (int s = 2; s < 4; s++)
                for (int r = 0; r < 4; r++)
                    for (int p = 0; p < 2; p++) begin
                        apply("R3 R4 main", mk(4'hE, u[0], s[1:0], p ? 4'hF : 4'h3, 4'h5, r[1:0], 4'h2),
                              next_rand(), 32'h80FF_7F01 ^ (next_rand() & 32'h7F7F_7F7F), 4'h0);
                        apply("R5 R6 pattern", mk(4'hE, u[0], s[1:0], p ? 4'hF : 4'h9, 4'hA, r[1:0], 4'h1),
                              next_rand(), next_rand(), 4'h0);
                    end

        // R9: idle cycle gives low strobes
        @(negedge clk);
        chk("R9 idle out_valid", {31'd0, out_valid}, 0);
        chk("R9 idle wr_en", {31'd0, wr_en}, 0);

        // R8: every condition code against every flag combination
        for (int c = 0; c < 15; c++)
            for (int f = 0; f < 16; f++)
                apply("R8 cond", mk(c[3:0], 1'b0, 2'b10, 4'h4, 4'h6, 2'd1, 4'h7),
                      32'h10, 32'h0000_8000, f[3:0]);

        // R6: wrapping add
        apply("R6 wrap", mk(4'hE, 1'b1, 2'b10, 4'h0, 4'h1, 2'd0, 4'h2), 32'hFFFF_FFFF, 32'h0000_0002, 4'h0);
        apply("R6 wrap neg", mk(4'hE, 1'b0, 2'b11, 4'h0, 4'h1, 2'd2, 4'h2), 32'h0000_0001, 32'hFFFE_0000, 4'h0);

        // R7: register 15 in each role, including with a failing condition
        apply("R7 rd15", mk(4'hE, 1'b0, 2'b10, 4'h1, 4'hF, 2'd0, 4'h2), 1, 2, 4'h0);
        apply("R7 rm15", mk(4'hE, 1'b1, 2'b11, 4'h1, 4'h3, 2'd0, 4'hF), 1, 2, 4'h0);
        apply("R7 rm15 cond fail", mk(4'h0, 1'b1, 2'b11, 4'h1, 4'h3, 2'd0, 4'hF), 1, 2, 4'h0);

        // R1: non-matching words
        apply("R1 dual lane", mk(4'hE, 1'b0, 2'b00, 4'h1, 4'h2, 2'd0, 4'h3), 1, 2, 4'h0);
        apply("R1 size01", mk(4'hE, 1'b1, 2'b01, 4'h1, 4'h2, 2'd0, 4'h3), 1, 2, 4'h0);
        apply("R1 cond15", mk(4'hF, 1'b0, 2'b10, 4'h1, 4'h2, 2'd0, 4'h3), 1, 2, 4'h0);
        apply("R1 minor", mk(4'hE, 1'b0, 2'b10, 4'h1, 4'h2, 2'd0, 4'h3) ^ 32'h0000_0020, 1, 2, 4'h0);
        apply("R1 major", mk(4'hE, 1'b0, 2'b10, 4'h1, 4'h2, 2'd0, 4'h3) ^ 32'h0100_0000, 1, 2, 4'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule